// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two signed N-bit two's complement operands and delivers the full 2N-bit signed product, one multiplier bit per clock. A high accumulator that is one bit wider than the operands sits above a low register. At the start the low register is loaded with the multiplier. Each step looks at the bit that sits in the low register's bit 0. It then adds the sign-extended multiplicand into the accumulator, or leaves the accumulator as it is. Finally it shifts the whole {accumulator, low} pair one place right while keeping the top bit. Product bits settle into the low register as the multiplier bits drain out of it.

The final step handles the multiplier's sign bit, which carries a negative weight. That step subtracts the multiplicand instead of adding it, so negative multipliers need no correction pass. A caller waits for `ready`, pulses `start` together with both operands, and reads `product` in the cycle where `done` is high. The product then stays in place until the next accepted start.

Top module: `smul_top`

## Requirements
- R1: After synchronous reset, `ready` is 1, `done` is 0 and `product` is all zeros.
- R2: When `done` is high, `product` equals the two's complement product of the signed operands that were captured at start, as a 2N-bit value.
- R3: `done` is high for exactly one cycle. That cycle follows the Nth rising edge after the edge at which `start` was accepted.
- R4: `ready` is 0 from the accepting edge until the result is ready, and `ready` is 1 again in the cycle where `done` is high.
- R5: A `start` that arrives while `ready` is 0 has no effect on the timing or the result of the operation in progress.
- R6: Both operands are captured at the accepting edge, and later changes on `mcand` or `mplier` do not affect the result.
- R7: A multiplier with its top bit set yields the correct negative or positive result. For example, 6 times -5 gives 16'hFFE2 at N=8.
- R8: The most negative operand times itself yields the positive value 2^(2N-2), which is 16'h4000 at N=8.
- R9: `product` holds its value from the `done` cycle until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only while ready is 1 |
| mcand | input | N | Signed multiplicand, captured on the accepting edge |
| mplier | input | N | Signed multiplier, captured on the accepting edge |
| ready | output | 1 | Idle and able to accept start |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 2N | Signed 2N-bit product |

## Verification
The assertions assume that `start` is a synchronous level, sampled only on rising edges. They also assume that reset is held for at least one edge before the first operation. The bench drives every input on the falling edge, so each level is stable across the sampling edge. It keeps reset high for several cycles before any stimulus. Operand changes and stray `start` pulses during a busy window are issued on purpose, because the design must tolerate them.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // width of a counter that must hold values 0 .. n-1
    function automatic int count_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/smul_addsub.sv
module smul_addsub #(
    parameter int W = 9
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    // ripple adder; subtract = a + ~b + 1 with the carry-in set
    logic [W-1:0] carry;
    logic [W-1:0] bx;

    assign carry[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bx[i] = b[i] ^ sub;
        assign y[i]  = a[i] ^ bx[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = (a[i] & bx[i]) | (carry[i] & (a[i] ^ bx[i]));
        end
    end

endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic ready,
    output logic done
);
    localparam int CW = count_bits(N);

    phase_e        phase;
    logic [CW-1:0] left;

    assign ready = (phase == PH_IDLE);
    assign load  = start && ready;
    assign step  = (phase == PH_RUN);
    assign last  = step && (left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            left  <= '0;
            done  <= 1'b0;
        end else begin
            done <= last;
            if (load) begin
                phase <= PH_RUN;
                left  <= CW'(N - 1);
            end else if (step) begin
                if (left == '0) phase <= PH_IDLE;
                else            left  <= left - 1'b1;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                   // R3
    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);                                   // R4
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        load |=> !ready);                                  // R4
    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (step && !last) |=> step);                         // R5

endmodule

// File: rtl/smul_dpath.sv
module smul_dpath #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic           last,
    input  logic [N-1:0]   mcand_in,
    input  logic [N-1:0]   mplier_in,
    output logic [2*N-1:0] product
);
    localparam int AW = N + 1;

    logic [N-1:0]  mcand_q;
    logic [AW-1:0] acc;
    logic [N-1:0]  low;
    logic [AW-1:0] addend;
    logic [AW-1:0] sum;
    logic [AW-1:0] nxt;

    assign addend = {mcand_q[N-1], mcand_q};

    smul_addsub #(.W(AW)) u_addsub (
        .a   (acc),
        .b   (addend),
        .sub (last),
        .y   (sum)
    );

    assign nxt     = low[0] ? sum : acc;
    assign product = {acc[N-1:0], low};

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            acc     <= '0;
            low     <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            acc     <= '0;
            low     <= mplier_in;
        end else if (step) begin
            acc <= {nxt[AW-1], nxt[AW-1:1]};
            low <= {nxt[0], low[N-1:1]};
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(product));            // R9
    AST_OPND_STABLE: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(mcand_q));                        // R6

endmodule

// File: rtl/smul_top.sv
module smul_top #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           ready,
    output logic           done,
    output logic [2*N-1:0] product
);
    logic load;
    logic step;
    logic last;

    smul_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .ready (ready),
        .done  (done)
    );

    smul_dpath #(.N(N)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .last      (last),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .product   (product)
    );

    AST_START_MEANS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (start && ready) |=> (!ready && !done));           // R4

endmodule

// File: tb/sim_smul_top.sv
module sim_smul_top;
    localparam int N = 8;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 100000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           ready;
    logic           done;
    logic [2*N-1:0] product;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    smul_top #(.N(N)) u0 (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .ready(ready), .done(done), .product(product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        return p[2*N-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference: remaining step count, expected result, done flag
    int             m_cnt = 0;
    bit             m_done = 0;
    bit             m_have = 0;
    logic [2*N-1:0] m_exp = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt  <= 0;
            m_done <= 0;
            m_have <= 0;
        end else if (m_cnt == 0 && start) begin
            m_cnt  <= N;
            m_exp  <= ref_mul(mcand, mplier);
            m_done <= 0;
            m_have <= 0;
        end else if (m_cnt > 0) begin
            m_cnt  <= m_cnt - 1;
            m_done <= (m_cnt == 1);
            if (m_cnt == 1) m_have <= 1;
        end else begin
            m_done <= 0;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk(ready == (m_cnt == 0), "R4 R5 ready", ready, (m_cnt == 0));
            chk(done == m_done, "R3 done", done, m_done);
            if (m_have)
                chk(product == m_exp, "R2 R6 R9 product", product, m_exp);
        end
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit disturb);
        @(negedge clk);
        while (!ready) @(negedge clk);
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            mcand = ~a; mplier = b ^ 8'h5A; start = 1'b1;  // R5 R6 stray inputs while busy
            @(negedge clk);
            start = 1'b0;
            mcand = a + 8'd3;
        end
        while (!done) @(negedge clk);
    endtask

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(ready === 1'b1, "R1 ready", ready, 1);
        chk(done === 1'b0, "R1 done", done, 0);
        chk(product === '0, "R1 product", product, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ready === 1'b1 && product === '0, "R1 idle after reset", product, 0);

        run_op(8'd6, 8'hFB, 0);
        chk(product == 16'hFFE2, "R7 6 x -5", product, 16'hFFE2);
        run_op(8'h80, 8'h80, 0);
        chk(product == 16'h4000, "R8 min x min", product, 16'h4000);
        run_op(8'h80, 8'h7F, 0);
        chk(product == 16'hC080, "R7 min x max", product, 16'hC080);
        run_op(8'h7F, 8'h7F, 0);
        chk(product == 16'h3F01, "R2 max x max", product, 16'h3F01);
        run_op(8'hFF, 8'hFF, 1);
        chk(product == 16'h0001, "R6 -1 x -1 with disturbance", product, 16'h0001);
        run_op(8'h00, 8'h80, 0);
        chk(product == 16'h0000, "R2 zero multiplicand", product, 0);
        run_op(8'hF1, 8'h0F, 1);
        chk(product == 16'hFF1F, "R5 -15 x 15 with stray start", product, 16'hFF1F);

        // R9: idle hold for several cycles
        repeat (6) @(negedge clk);
        chk(product == 16'hFF1F, "R9 hold", product, 16'hFF1F);

        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_op(lfsr[7:0], lfsr[15:8], i[0]);
            chk(product == ref_mul(lfsr[7:0], lfsr[15:8]), "R2 sweep",
                product, ref_mul(lfsr[7:0], lfsr[15:8]));
        end

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule